// File: doc/BRIEF.md
# Receive destination address filter

This block sits on the receive side of an Ethernet MAC. It watches the byte stream of each incoming frame and takes in its first six bytes, which form the destination address. From them it decides whether the frame is kept or dropped. The decision is registered one cycle after the sixth byte is taken and stays on the outputs until the next frame begins. Frame storage, descriptor handling and checksums are left to the logic around it.

Software programs the filter through a 32-bit register port. The port holds a receive configuration word with enable, promiscuous and hash-enable bits, a 48-bit station address split over three 16-bit registers, and a 64-bit multicast hash table split over four 16-bit registers. The rules are tried in a fixed priority. Promiscuous mode comes first, then an exact station match, then the broadcast address, then a hash lookup. The hash lookup uses the top six bits of a reflected CRC-32, computed a byte at a time while the address streams in. A one-cycle pulse is raised when reception is switched on, so that an upstream queue knows it may start delivering frames.

Top module: `rx_dest_filter`

## Requirements
- R1: After reset, `dec_valid`, `dec_accept` and `flush_req` are 0 and every register address reads 0.
- R2: While configuration bit 0 (enable) is 0, every decision is a reject, even for broadcast or promiscuous settings.
- R3: With enable set and configuration bit 6 (promiscuous) set, every destination is accepted.
- R4: With enable set, a destination equal to the station address is accepted. Destination byte 0 is compared with bits 15:8 of address 1 and byte 1 with bits 7:0 of address 1. Bytes 2 and 3 are compared the same way with address 2, and bytes 4 and 5 with address 3.
- R5: With enable set, the destination FF:FF:FF:FF:FF:FF is always accepted.
- R6: With enable set and configuration bit 11 (hash enable) set, a destination that matches neither the station nor the broadcast rule is looked up in the hash table. The filter takes the reflected CRC-32 of the six bytes, each byte fed LSB first, with all-ones seed, polynomial 0xEDB88320 and no final inversion, and uses its bits 31:26 as a 6-bit index. Index bits 5:4 with value v select the hash register at address 7−v. Index bits 3:0 select the bit in that register. The frame is accepted when that bit is 1.
- R7: While hash enable is 0, the hash table has no effect on the decision.
- R8: A frame that no rule accepts is rejected.
- R9: `dec_valid` rises in the cycle after the edge that takes the sixth destination byte. `dec_valid` and `dec_accept` then hold through any further bytes of the frame. The next byte flagged with `rx_sof` clears `dec_valid`.
- R10: `flush_req` is a single-cycle pulse. It is raised in the cycle after a write to address 0 that changes enable from 0 to 1, and never at any other time.
- R11: The register map is: address 0 is configuration, addresses 1–3 are station address, addresses 4–7 are hash table. Configuration reads back all 32 written bits. The other registers keep 16 bits and read their upper 16 bits as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | REG_AW (3) | Register word address |
| reg_wdata | input | DATA_W (32) | Register write data |
| reg_rdata | output | DATA_W (32) | Register read data, combinational from `reg_addr` |
| rx_valid | input | 1 | Receive byte valid |
| rx_sof | input | 1 | Marks the first byte of a frame |
| rx_data | input | 8 | Receive byte |
| dec_valid | output | 1 | Decision is valid for the current frame |
| dec_accept | output | 1 | 1 = keep frame, 0 = drop |
| flush_req | output | 1 | Pulse when reception becomes enabled |

## Verification
The hardest situation to reach from the ports is a hash hit. Because the index comes out of a CRC, no hand-picked destination lands on a chosen table bit. The bench recomputes the index its own way, with a bit-serial loop over the 48 address bits. It then programs exactly the selected bit in the register that the descending order picks, and expects an accept. Around that hit it tries near misses: the neighbouring bit in the same register, the same bit in the mirrored register, and the correct bit with hash enable cleared. Several destinations are run so that different registers are selected.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
  localparam int unsigned HALF_W          = 16;
  localparam int unsigned CFG_EN_BIT      = 0;
  localparam int unsigned CFG_PROMISC_BIT = 6;
  localparam int unsigned CFG_HASH_BIT    = 11;
  localparam logic [31:0] CRC_SEED        = 32'hFFFF_FFFF;
  localparam logic [31:0] CRC_POLY_REFL   = 32'hEDB8_8320;

  typedef enum logic [2:0] {
    HIT_NONE,
    HIT_PROMISC,
    HIT_STATION,
    HIT_BCAST,
    HIT_HASH
  } hit_e;

  // One byte of reflected CRC-32, least significant bit first.
  function automatic logic [31:0] crc_step_byte(input logic [31:0] crc_in,
                                                input logic [7:0]  b);
    logic [31:0] c;
    c = crc_in ^ {24'd0, b};
    for (int i = 0; i < 8; i++) begin
      c = c[0] ? ((c >> 1) ^ CRC_POLY_REFL) : (c >> 1);
    end
    return c;
  endfunction
endpackage

// File: rtl/rxf_regs.sv
module rxf_regs
  import rxf_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int STA_REGS  = 3,
  parameter int HASH_REGS = 4,
  parameter int REG_AW    = 3
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        reg_wr,
  input  logic [REG_AW-1:0]           reg_addr,
  input  logic [DATA_W-1:0]           reg_wdata,
  output logic [DATA_W-1:0]           reg_rdata,
  output logic                        cfg_en,
  output logic                        cfg_promisc,
  output logic                        cfg_hash,
  output logic [STA_REGS*HALF_W-1:0]  station_flat,
  output logic [HASH_REGS*HALF_W-1:0] hash_flat,
  output logic                        enable_rise
);
  localparam int HASH_BASE = 1 + STA_REGS;

  logic [DATA_W-1:0] cfg_q;
  logic [HALF_W-1:0] sta_q  [STA_REGS];
  logic [HALF_W-1:0] hash_q [HASH_REGS];
  logic              cfg_sel;

  assign cfg_sel = reg_wr && (reg_addr == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q       <= '0;
      enable_rise <= 1'b0;
    end else begin
      enable_rise <= cfg_sel && reg_wdata[CFG_EN_BIT] && !cfg_q[CFG_EN_BIT];
      if (cfg_sel) cfg_q <= reg_wdata;
    end
  end

  // Station words: word 0 carries destination bytes 0 (high) and 1.
  for (genvar k = 0; k < STA_REGS; k++) begin : g_sta
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                      sta_q[k] <= '0;
      else if (reg_wr && reg_addr == REG_AW'(k + 1))   sta_q[k] <= reg_wdata[HALF_W-1:0];
    end
    assign station_flat[(STA_REGS-1-k)*HALF_W +: HALF_W] = sta_q[k];
  end

  for (genvar k = 0; k < HASH_REGS; k++) begin : g_hash
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                          hash_q[k] <= '0;
      else if (reg_wr && reg_addr == REG_AW'(HASH_BASE+k)) hash_q[k] <= reg_wdata[HALF_W-1:0];
    end
    assign hash_flat[k*HALF_W +: HALF_W] = hash_q[k];
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == '0) reg_rdata = cfg_q;
    for (int k = 0; k < STA_REGS; k++)
      if (reg_addr == REG_AW'(k + 1)) reg_rdata = DATA_W'(sta_q[k]);
    for (int k = 0; k < HASH_REGS; k++)
      if (reg_addr == REG_AW'(HASH_BASE + k)) reg_rdata = DATA_W'(hash_q[k]);
  end

  assign cfg_en      = cfg_q[CFG_EN_BIT];
  assign cfg_promisc = cfg_q[CFG_PROMISC_BIT];
  assign cfg_hash    = cfg_q[CFG_HASH_BIT];
endmodule

// File: rtl/rxf_capture.sv
module rxf_capture
  import rxf_pkg::*;
#(
  parameter int ADDR_BYTES = 6,
  parameter int HASH_W     = 6
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    rx_valid,
  input  logic                    rx_sof,
  input  logic [7:0]              rx_data,
  output logic                    frame_start,
  output logic                    last_byte,
  output logic [ADDR_BYTES*8-1:0] dst_next,
  output logic [HASH_W-1:0]       hash_idx_next
);
  localparam int CNT_W = $clog2(ADDR_BYTES + 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] pos;
  logic [7:0]       dst_q [ADDR_BYTES];
  logic [31:0]      crc_q, crc_next;
  logic             take_byte;

  // cnt_q == 0: no frame seen yet; == ADDR_BYTES: address complete.
  assign take_byte   = rx_valid && (rx_sof || (cnt_q != '0 && cnt_q < CNT_W'(ADDR_BYTES)));
  assign pos         = rx_sof ? '0 : cnt_q;
  assign frame_start = rx_valid && rx_sof;
  assign last_byte   = take_byte && (pos == CNT_W'(ADDR_BYTES - 1));
  assign crc_next    = crc_step_byte(rx_sof ? CRC_SEED : crc_q, rx_data);
  assign hash_idx_next = crc_next[31 -: HASH_W];

  // Look-ahead view: stored bytes with the byte now arriving merged in.
  for (genvar k = 0; k < ADDR_BYTES; k++) begin : g_dst
    assign dst_next[(ADDR_BYTES-1-k)*8 +: 8] =
      (take_byte && pos == CNT_W'(k)) ? rx_data : dst_q[k];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      crc_q <= CRC_SEED;
      for (int k = 0; k < ADDR_BYTES; k++) dst_q[k] <= '0;
    end else if (take_byte) begin
      cnt_q      <= pos + CNT_W'(1);
      crc_q      <= crc_next;
      dst_q[pos] <= rx_data;
    end
  end
endmodule

// File: rtl/rxf_decide.sv
module rxf_decide
  import rxf_pkg::*;
#(
  parameter int ADDR_BYTES = 6,
  parameter int HASH_W     = 6
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  frame_start,
  input  logic                                  last_byte,
  input  logic [ADDR_BYTES*8-1:0]               dst_next,
  input  logic [HASH_W-1:0]                     hash_idx,
  input  logic                                  cfg_en,
  input  logic                                  cfg_promisc,
  input  logic                                  cfg_hash,
  input  logic [ADDR_BYTES*8-1:0]               station,
  input  logic [(2**(HASH_W-4))*HALF_W-1:0]     hash_flat,
  output logic                                  dec_valid,
  output logic                                  dec_accept
);
  localparam int HASH_REGS = 2 ** (HASH_W - 4);
  localparam int ROW_W     = HASH_W - 4;

  logic [ROW_W-1:0]  row_sel;
  logic [HALF_W-1:0] hash_row;
  logic              is_station, is_bcast, hash_bit;
  hit_e              hit;

  assign is_station = (dst_next == station);
  assign is_bcast   = &dst_next;
  // Table registers are taken in descending address order.
  assign row_sel    = ROW_W'(HASH_REGS - 1) - hash_idx[HASH_W-1 -: ROW_W];
  assign hash_row   = hash_flat[int'(row_sel)*HALF_W +: HALF_W];
  assign hash_bit   = hash_row[hash_idx[3:0]];

  always_comb begin
    hit = HIT_NONE;
    if (cfg_en) begin
      if (cfg_promisc)               hit = HIT_PROMISC;
      else if (is_station)           hit = HIT_STATION;
      else if (is_bcast)             hit = HIT_BCAST;
      else if (cfg_hash && hash_bit) hit = HIT_HASH;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dec_valid  <= 1'b0;
      dec_accept <= 1'b0;
    end else if (last_byte) begin
      dec_valid  <= 1'b1;
      dec_accept <= (hit != HIT_NONE);
    end else if (frame_start) begin
      dec_valid  <= 1'b0;
      dec_accept <= 1'b0;
    end
  end
endmodule

// File: rtl/rx_dest_filter.sv
module rx_dest_filter
  import rxf_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int ADDR_BYTES = 6,
  parameter int HASH_W     = 6,
  parameter int REG_AW     = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              rx_valid,
  input  logic              rx_sof,
  input  logic [7:0]        rx_data,
  output logic              dec_valid,
  output logic              dec_accept,
  output logic              flush_req
);
  localparam int STA_REGS  = ADDR_BYTES / 2;
  localparam int HASH_REGS = 2 ** (HASH_W - 4);
  localparam int AW        = ADDR_BYTES * 8;

  logic                        cfg_en, cfg_promisc, cfg_hash;
  logic [STA_REGS*HALF_W-1:0]  station_flat;
  logic [HASH_REGS*HALF_W-1:0] hash_flat;
  logic                        frame_start, last_byte;
  logic [AW-1:0]               dst_next;
  logic [HASH_W-1:0]           hash_idx;

  rxf_regs #(
    .DATA_W(DATA_W), .STA_REGS(STA_REGS), .HASH_REGS(HASH_REGS), .REG_AW(REG_AW)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .cfg_en(cfg_en), .cfg_promisc(cfg_promisc), .cfg_hash(cfg_hash),
    .station_flat(station_flat), .hash_flat(hash_flat), .enable_rise(flush_req)
  );

  rxf_capture #(.ADDR_BYTES(ADDR_BYTES), .HASH_W(HASH_W)) u_capture (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_sof(rx_sof),
    .rx_data(rx_data), .frame_start(frame_start), .last_byte(last_byte),
    .dst_next(dst_next), .hash_idx_next(hash_idx)
  );

  rxf_decide #(.ADDR_BYTES(ADDR_BYTES), .HASH_W(HASH_W)) u_decide (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .last_byte(last_byte),
    .dst_next(dst_next), .hash_idx(hash_idx), .cfg_en(cfg_en),
    .cfg_promisc(cfg_promisc), .cfg_hash(cfg_hash), .station(station_flat),
    .hash_flat(hash_flat), .dec_valid(dec_valid), .dec_accept(dec_accept)
  );
endmodule

// File: rtl/rxf_checker.sv
module rxf_checker (
  input logic clk,
  input logic rst_n,
  input logic rx_valid,
  input logic rx_sof,
  input logic last_byte,
  input logic cfg_en,
  input logic cfg_promisc,
  input logic dec_valid,
  input logic dec_accept,
  input logic flush_req
);
  AST_VALID_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    last_byte |=> dec_valid);  // R9
  AST_DECISION_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && !(rx_valid && rx_sof)) |=> (dec_valid && $stable(dec_accept)));  // R9
  AST_CLEAR_ON_SOF: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && rx_sof && !last_byte) |=> !dec_valid);  // R9
  AST_DISABLED_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(dec_valid) && !$past(cfg_en)) |-> !dec_accept);  // R2
  AST_PROMISC_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(dec_valid) && $past(cfg_en) && $past(cfg_promisc)) |-> dec_accept);  // R3
  AST_FLUSH_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    flush_req |=> !flush_req);  // R10
  AST_FLUSH_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    flush_req |-> (cfg_en && !$past(cfg_en)));  // R10
endmodule

bind rx_dest_filter rxf_checker u_chk (
  .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_sof(rx_sof),
  .last_byte(last_byte), .cfg_en(cfg_en), .cfg_promisc(cfg_promisc),
  .dec_valid(dec_valid), .dec_accept(dec_accept), .flush_req(flush_req)
);

// File: tb/rx_dest_filter_bench.sv
module rx_dest_filter_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        rx_valid = 1'b0;
  logic        rx_sof = 1'b0;
  logic [7:0]  rx_data = '0;
  logic        dec_valid, dec_accept, flush_req;

  int  n_checks = 0;
  int  n_fails  = 0;
  bit  reported = 0;

  localparam logic [31:0] EN = 32'h1, PROM = 32'h40, HEN = 32'h800;

  always #10 clk = ~clk;  // 50 MHz

  rx_dest_filter u_rx_dest_filter (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .rx_valid(rx_valid),
    .rx_sof(rx_sof), .rx_data(rx_data), .dec_valid(dec_valid),
    .dec_accept(dec_accept), .flush_req(flush_req)
  );

  task automatic chk(input bit ok, input string req,
                     input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic report();
    if (!reported) begin
      reported = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    end
  endtask

  task automatic reg_write(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic reg_read(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  // Bit-serial reflected CRC over the six destination bytes.
  function automatic logic [5:0] ref_hash(input logic [47:0] d);
    logic [31:0] c;
    c = 32'hFFFF_FFFF;
    for (int n = 0; n < 48; n++) begin
      logic fb;
      fb = c[0] ^ d[40 - 8*(n/8) + (n%8)];
      c  = c >> 1;
      if (fb) c = c ^ 32'hEDB8_8320;
    end
    return c[31:26];
  endfunction

  task automatic send_dst(input logic [47:0] d, input bit exp_acc, input string req);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      rx_valid = 1'b1; rx_sof = (i == 0); rx_data = d[47 - 8*i -: 8];
      if (i == 5) chk(dec_valid === 1'b0, "R9 valid low before last byte", dec_valid, 0);
    end
    @(negedge clk);
    rx_valid = 1'b0; rx_sof = 1'b0;
    chk(dec_valid === 1'b1, "R9 valid after sixth byte", dec_valid, 1);
    chk(dec_accept === exp_acc, req, dec_accept, exp_acc);
  endtask

  task automatic clear_hash();
    for (int a = 4; a < 8; a++) reg_write(3'(a), 32'h0);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    chk(dec_valid === 1'b0, "R1 dec_valid", dec_valid, 0);
    chk(dec_accept === 1'b0, "R1 dec_accept", dec_accept, 0);
    chk(flush_req === 1'b0, "R1 flush_req", flush_req, 0);
    for (int a = 0; a < 8; a++) begin
      reg_read(3'(a), v);
      chk(v === 32'h0, "R1 register reset", v, 0);
    end
  endtask

  task automatic t_regs();
    logic [31:0] v;
    reg_write(0, 32'hA5A5_0000);
    reg_read(0, v);
    chk(v === 32'hA5A5_0000, "R11 config readback", v, 32'hA5A5_0000);
    reg_write(2, 32'hABCD_1234);
    reg_read(2, v);
    chk(v === 32'h0000_1234, "R11 station upper bits", v, 32'h1234);
    reg_write(6, 32'hFFFF_BEEF);
    reg_read(6, v);
    chk(v === 32'h0000_BEEF, "R11 hash upper bits", v, 32'hBEEF);
    reg_write(0, 32'h0);
    chk(flush_req === 1'b0, "R10 no flush when enable stays 0", flush_req, 0);
    reg_write(6, 32'h0);
  endtask

  task automatic t_flush();
    reg_write(0, EN);
    chk(flush_req === 1'b1, "R10 flush on enable rise", flush_req, 1);
    @(negedge clk);
    chk(flush_req === 1'b0, "R10 flush single cycle", flush_req, 0);
    reg_write(0, EN | PROM);
    chk(flush_req === 1'b0, "R10 no flush when already enabled", flush_req, 0);
    reg_write(0, 32'h0);
    chk(flush_req === 1'b0, "R10 no flush on disable", flush_req, 0);
    reg_write(0, EN);
    chk(flush_req === 1'b1, "R10 flush on second rise", flush_req, 1);
  endtask

  task automatic t_disabled();
    reg_write(1, 32'h0211); reg_write(2, 32'h2233); reg_write(3, 32'h4455);
    reg_write(0, PROM | HEN);
    send_dst(48'hFFFF_FFFF_FFFF, 0, "R2 broadcast dropped while disabled");
    send_dst(48'h0211_2233_4455, 0, "R2 station dropped while disabled");
  endtask

  task automatic t_station();
    reg_write(0, EN);
    send_dst(48'h0211_2233_4455, 1, "R4 station match");
    send_dst(48'h1102_2233_4455, 0, "R4 byte order within word");
    send_dst(48'h0211_2233_4454, 0, "R8 last byte differs");
    send_dst(48'h4455_2233_0211, 0, "R4 word order");
  endtask

  task automatic t_bcast();
    reg_write(0, EN);
    send_dst(48'hFFFF_FFFF_FFFF, 1, "R5 broadcast");
    send_dst(48'hFFFF_FFFF_FFFE, 0, "R8 near broadcast rejected");
  endtask

  task automatic t_promisc();
    reg_write(0, EN | PROM);
    send_dst(48'h3C5A_9001_7E22, 1, "R3 promiscuous any address");
    send_dst(48'h0000_0000_0000, 1, "R3 promiscuous zero address");
  endtask

  task automatic t_hash();
    logic [47:0] dsts [4];
    dsts[0] = 48'h0100_5E00_0001; dsts[1] = 48'h3333_0000_00FB;
    dsts[2] = 48'h0180_C200_000E; dsts[3] = 48'h0100_5E7F_FFFA;
    for (int n = 0; n < 4; n++) begin
      logic [5:0]  idx;
      logic [2:0]  good_a, bad_a;
      idx    = ref_hash(dsts[n]);
      good_a = 3'(7 - idx[5:4]);
      bad_a  = 3'(4 + idx[5:4]);
      if (bad_a == good_a) bad_a = 3'(4 + ((idx[5:4] + 1) % 4));
      clear_hash();
      reg_write(0, EN | HEN);
      reg_write(good_a, 32'(1) << idx[3:0]);
      send_dst(dsts[n], 1, "R6 hash bit hit");
      reg_write(0, EN);
      send_dst(dsts[n], 0, "R7 hash disabled ignores table");
      reg_write(0, EN | HEN);
      reg_write(good_a, 32'(1) << (idx[3:0] ^ 4'h1));
      send_dst(dsts[n], 0, "R6 neighbour bit misses");
      reg_write(good_a, 32'h0);
      reg_write(bad_a, 32'(1) << idx[3:0]);
      send_dst(dsts[n], 0, "R6 wrong register misses");
    end
    clear_hash();
    send_dst(48'h0100_5E00_0001, 0, "R8 empty hash table rejects");
  endtask

  task automatic t_timing();
    reg_write(0, EN);
    send_dst(48'hFFFF_FFFF_FFFF, 1, "R5 broadcast before trailing bytes");
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      rx_valid = 1'b1; rx_sof = 1'b0; rx_data = 8'h00;
    end
    @(negedge clk);
    rx_valid = 1'b0;
    chk(dec_valid === 1'b1, "R9 valid held through payload", dec_valid, 1);
    chk(dec_accept === 1'b1, "R9 accept held through payload", dec_accept, 1);
    @(negedge clk);
    rx_valid = 1'b1; rx_sof = 1'b1; rx_data = 8'h12;
    @(negedge clk);
    rx_valid = 1'b0; rx_sof = 1'b0;
    chk(dec_valid === 1'b0, "R9 cleared by start of frame", dec_valid, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_regs();
    t_flush();
    t_disabled();
    t_station();
    t_bcast();
    t_promisc();
    t_hash();
    t_timing();
    repeat (2) @(negedge clk);
    report();
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++;
    n_fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
    $finish;
  end
endmodule